// File: doc/BRIEF.md
# PLL Divider Programming Front End

This block loads the divide values of an integer-N synthesizer. Software or a host controller programs a 20-bit working word that holds the main divider value M (9 bits), the swallow value A (4 bits), the reference divider value R (6 bits) and a prescaler enable bit. It also programs an 8-bit register of auxiliary enhancement bits. Loading uses either a bit-serial stream or byte-wide writes, and each byte write has its own field strobe. A third mode ignores both registers and drives the counter fields straight from static pins.

The block is double-buffered. A hop strobe, or the end of a serial load, copies the working word into a held word. A select line then picks the working or the held word as the live divide values. A controller can stage the next channel while the current one stays in force, and switch between them with one line. All strobes and data are synchronized to the system clock by a two-stage synchronizer. A strobe acts on its synchronized rising edge.

The interface mode is a three-state machine with states PARALLEL, SERIAL and DIRECT. The state register loads each cycle from the synchronized mode pins. Any state goes to DIRECT when `mode_direct` is 1. Any state goes to SERIAL when `mode_direct` is 0 and `mode_serial` is 1. Any state goes to PARALLEL when both are 0. Reset enters PARALLEL.

Top module: `pllcfg_front`

## Requirements
- R1: `mode_direct`=1 selects DIRECT, in which `m_out`={2'b00,`dir_m`}, `a_out`=`dir_a`, `r_out`={2'b00,`dir_r`}, `pe_out`=`dir_pe` and `enh_out`=0. `mode_direct`=0 with `mode_serial`=1 selects SERIAL, and both 0 select PARALLEL.
- R2: In SERIAL, each rising edge of `ser_clk` taken while `ser_load_n` is low shifts `ser_data` into the working word at bit 0, MSB first, when `enh_sel` is low. A `ser_clk` edge while `ser_load_n` is high shifts nothing.
- R3: In SERIAL with `enh_sel` high, the same shifting goes into the 8-bit enhancement register instead, and the working word is left untouched.
- R4: In SERIAL, a rising edge of `ser_load_n` copies the working word into the held word.
- R5: In SERIAL or PARALLEL, a rising edge of `hop_wr` copies the working word into the held word.
- R6: The working word layout is R=[19:14], prescaler enable=[13], M=[12:4], A=[3:0]. The live fields come from the working word when the mode's select is 1 and from the held word when it is 0. The select is `fsel_ser` in SERIAL and `fsel_par` in PARALLEL.
- R7: In PARALLEL, a rising edge of `wr_m1` loads `par_data`[7] into the prescaler enable and `par_data`[6:0] into M[6:0].
- R8: In PARALLEL, a rising edge of `wr_m2` loads `par_data`[3:2] into R[5:4] and `par_data`[1:0] into M[8:7].
- R9: In PARALLEL, a rising edge of `wr_a` loads `par_data`[7:4] into R[3:0] and `par_data`[3:0] into A.
- R10: In PARALLEL, a rising edge of `enh_sel` loads `par_data` into the enhancement register.
- R11: `enh_out` shows the enhancement register only while `enh_en_n` is 0 and the mode is not DIRECT. Otherwise it is 0.
- R12: Strobes of an inactive mode have no effect. Field writes in SERIAL and `ser_clk` edges in PARALLEL leave both registers unchanged.
- R13: When a hop edge and a field write act in the same cycle, the held word gets the working word as it was before that write, and the working word takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_direct | input | 1 | 1 selects direct pin mode |
| mode_serial | input | 1 | With mode_direct=0: 1 serial, 0 parallel |
| ser_clk | input | 1 | Serial shift clock (edge sampled) |
| ser_load_n | input | 1 | Serial load enable, low to shift; rising edge copies |
| ser_data | input | 1 | Serial data bit |
| enh_sel | input | 1 | Serial: route to enhancement register; parallel: enhancement write strobe |
| par_data | input | 8 | Parallel data byte |
| wr_m1 | input | 1 | Parallel write of prescaler enable and M[6:0] |
| wr_m2 | input | 1 | Parallel write of R[5:4] and M[8:7] |
| wr_a | input | 1 | Parallel write of R[3:0] and A |
| hop_wr | input | 1 | Copy working word to held word |
| fsel_ser | input | 1 | Serial mode source select (1 working, 0 held) |
| fsel_par | input | 1 | Parallel mode source select (1 working, 0 held) |
| enh_en_n | input | 1 | Active-low enable of the enhancement outputs |
| dir_m | input | 7 | Direct mode M[6:0] |
| dir_pe | input | 1 | Direct mode prescaler enable |
| dir_a | input | 4 | Direct mode A |
| dir_r | input | 4 | Direct mode R[3:0] |
| m_out | output | 9 | Live M value |
| a_out | output | 4 | Live A value |
| r_out | output | 6 | Live R value |
| pe_out | output | 1 | Live prescaler enable |
| enh_out | output | 8 | Gated enhancement bits |

## Verification
A hop copy and a parallel field write can act on the registers in the same clock cycle. The bench provokes this by raising `hop_wr` and `wr_a` at the same instant, so both strobes pass the synchronizer together. It then reads the held word with `fsel_par`=0 and expects the working word from before the write. It reads the working word with `fsel_par`=1 and expects the newly written R[3:0] and A. A serial clock edge that meets the rising edge of the load enable is the second such pair. It must copy without shifting.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;
    localparam int M_W    = 9;
    localparam int A_W    = 4;
    localparam int R_W    = 6;
    localparam int D_W    = 8;
    localparam int ENH_W  = 8;
    localparam int PRIM_W = R_W + 1 + M_W + A_W;
    // working word layout: {R, prescaler enable, M, A}
    localparam int A_LSB  = 0;
    localparam int M_LSB  = A_W;
    localparam int PE_BIT = A_W + M_W;
    localparam int R_LSB  = PE_BIT + 1;
    // split of M and R across the byte writes
    localparam int M_LO_W = D_W - 1;
    localparam int M_HI_W = M_W - M_LO_W;
    localparam int R_LO_W = D_W - A_W;
    localparam int R_HI_W = R_W - R_LO_W;
    // strobe vector indices
    localparam int STB_SCLK  = 0;
    localparam int STB_SLOAD = 1;
    localparam int STB_HOP   = 2;
    localparam int STB_WM1   = 3;
    localparam int STB_WM2   = 4;
    localparam int STB_WA    = 5;
    localparam int STB_ESEL  = 6;
    localparam int STB_N     = 7;
    // data vector: {mode_serial, mode_direct, par_data, ser_data}
    localparam int DAT_N     = D_W + 3;

    typedef enum logic [1:0] {
        ST_PAR = 2'd0,
        ST_SER = 2'd1,
        ST_DIR = 2'd2
    } mode_e;
endpackage

// File: rtl/pllcfg_sync.sv
module pllcfg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pllcfg_regs.sv
module pllcfg_regs
    import pllcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_p,
    input  logic              to_enh,
    input  logic              sbit,
    input  logic              copy_p,
    input  logic              wm1_p,
    input  logic              wm2_p,
    input  logic              wa_p,
    input  logic              we_p,
    input  logic [D_W-1:0]    pd,
    output logic [PRIM_W-1:0] prim,
    output logic [PRIM_W-1:0] sec,
    output logic [ENH_W-1:0]  enh
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prim <= '0;
            sec  <= '0;
            enh  <= '0;
        end else begin
            // copy uses the pre-update working word
            if (copy_p) sec <= prim;
            if (shift_p && !to_enh) prim <= {prim[PRIM_W-2:0], sbit};
            if (shift_p && to_enh)  enh  <= {enh[ENH_W-2:0], sbit};
            if (wm1_p) begin
                prim[PE_BIT]            <= pd[D_W-1];
                prim[M_LSB +: M_LO_W]   <= pd[M_LO_W-1:0];
            end
            if (wm2_p) begin
                prim[R_LSB+R_LO_W +: R_HI_W] <= pd[M_HI_W +: R_HI_W];
                prim[M_LSB+M_LO_W +: M_HI_W] <= pd[M_HI_W-1:0];
            end
            if (wa_p) begin
                prim[R_LSB +: R_LO_W] <= pd[D_W-1 -: R_LO_W];
                prim[A_LSB +: A_W]    <= pd[A_W-1:0];
            end
            if (we_p) enh <= pd;
        end
    end
endmodule

// File: rtl/pllcfg_front.sv
module pllcfg_front
    import pllcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_direct,
    input  logic              mode_serial,
    input  logic              ser_clk,
    input  logic              ser_load_n,
    input  logic              ser_data,
    input  logic              enh_sel,
    input  logic [7:0]        par_data,
    input  logic              wr_m1,
    input  logic              wr_m2,
    input  logic              wr_a,
    input  logic              hop_wr,
    input  logic              fsel_ser,
    input  logic              fsel_par,
    input  logic              enh_en_n,
    input  logic [6:0]        dir_m,
    input  logic              dir_pe,
    input  logic [3:0]        dir_a,
    input  logic [3:0]        dir_r,
    output logic [8:0]        m_out,
    output logic [3:0]        a_out,
    output logic [5:0]        r_out,
    output logic              pe_out,
    output logic [7:0]        enh_out
);
    logic [STB_N-1:0]  stb_raw, stb_lvl, stb_prev_q, stb_rise;
    logic [DAT_N-1:0]  dat_raw, dat_lvl;
    logic [PRIM_W-1:0] prim_q, sec_q, src;
    logic [ENH_W-1:0]  enh_q;
    mode_e             state_q, state_d;
    logic              is_ser, is_par;
    logic              shift_p, copy_p, wm1_p, wm2_p, wa_p, we_p;

    assign stb_raw = {enh_sel, wr_a, wr_m2, wr_m1, hop_wr, ser_load_n, ser_clk};
    assign dat_raw = {mode_serial, mode_direct, par_data, ser_data};

    pllcfg_sync #(.W(STB_N), .STAGES(SYNC_STAGES)) u_sync_stb (
        .clk(clk), .rst_n(rst_n), .din(stb_raw), .dout(stb_lvl)
    );
    pllcfg_sync #(.W(DAT_N), .STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .din(dat_raw), .dout(dat_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_prev_q <= '0;
        else        stb_prev_q <= stb_lvl;
    end
    assign stb_rise = stb_lvl & ~stb_prev_q;

    // next-state decode from synchronized mode pins
    always_comb begin
        if (dat_lvl[D_W+1])      state_d = ST_DIR;
        else if (dat_lvl[D_W+2]) state_d = ST_SER;
        else                     state_d = ST_PAR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PAR;
        else        state_q <= state_d;
    end

    assign is_ser  = (state_q == ST_SER);
    assign is_par  = (state_q == ST_PAR);
    assign shift_p = is_ser & stb_rise[STB_SCLK] & ~stb_lvl[STB_SLOAD];
    assign copy_p  = (is_ser & stb_rise[STB_SLOAD]) |
                     ((is_ser | is_par) & stb_rise[STB_HOP]);
    assign wm1_p   = is_par & stb_rise[STB_WM1];
    assign wm2_p   = is_par & stb_rise[STB_WM2];
    assign wa_p    = is_par & stb_rise[STB_WA];
    assign we_p    = is_par & stb_rise[STB_ESEL];

    pllcfg_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .shift_p(shift_p), .to_enh(stb_lvl[STB_ESEL]), .sbit(dat_lvl[0]),
        .copy_p(copy_p), .wm1_p(wm1_p), .wm2_p(wm2_p), .wa_p(wa_p), .we_p(we_p),
        .pd(dat_lvl[D_W:1]),
        .prim(prim_q), .sec(sec_q), .enh(enh_q)
    );

    // output process per state
    always_comb begin
        src     = sec_q;
        m_out   = '0;
        a_out   = '0;
        r_out   = '0;
        pe_out  = 1'b0;
        enh_out = '0;
        unique case (state_q)
            ST_DIR: begin
                m_out  = {{M_HI_W{1'b0}}, dir_m};
                a_out  = dir_a;
                r_out  = {{R_HI_W{1'b0}}, dir_r};
                pe_out = dir_pe;
            end
            ST_SER, ST_PAR: begin
                if ((is_ser && fsel_ser) || (is_par && fsel_par)) src = prim_q;
                m_out   = src[M_LSB +: M_W];
                a_out   = src[A_LSB +: A_W];
                r_out   = src[R_LSB +: R_W];
                pe_out  = src[PE_BIT];
                enh_out = enh_en_n ? '0 : enh_q;
            end
            default: begin
                m_out = '0;
            end
        endcase
    end
endmodule

// File: rtl/pllcfg_front_chk.sv
module pllcfg_front_chk
    import pllcfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input mode_e             state,
    input logic [PRIM_W-1:0] prim,
    input logic [PRIM_W-1:0] sec,
    input logic [STB_N-1:0]  rise,
    input logic [STB_N-1:0]  lvl,
    input logic [DAT_N-1:0]  dat,
    input logic              fsel_ser,
    input logic              fsel_par,
    input logic              enh_en_n,
    input logic [3:0]        dir_a,
    input logic [3:0]        a_out,
    input logic [7:0]        enh_out
);
    // R1
    dir_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIR) |-> (a_out == dir_a && enh_out == '0));

    // R2
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SER && rise[STB_SCLK] && !lvl[STB_SLOAD] && !lvl[STB_ESEL])
        |=> prim == {$past(prim[PRIM_W-2:0]), $past(dat[0])});

    // R4
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SER && rise[STB_SLOAD]) |=> sec == $past(prim));

    // R5
    hop_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DIR && rise[STB_HOP]) |=> sec == $past(prim));

    // R6
    sel_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SER && fsel_ser) |-> a_out == prim[A_LSB +: A_W]);

    // R6
    sel_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAR && !fsel_par) |-> a_out == sec[A_LSB +: A_W]);

    // R11
    enh_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enh_en_n |-> enh_out == '0);

    // R12
    ser_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SER && !rise[STB_SCLK]) |=> $stable(prim));
endmodule

bind pllcfg_front pllcfg_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .prim(prim_q), .sec(sec_q),
    .rise(stb_rise), .lvl(stb_lvl), .dat(dat_lvl),
    .fsel_ser(fsel_ser), .fsel_par(fsel_par), .enh_en_n(enh_en_n),
    .dir_a(dir_a), .a_out(a_out), .enh_out(enh_out)
);

// File: tb/tb_pllcfg_front.sv
module tb_pllcfg_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_direct = 1'b0, mode_serial = 1'b0;
    logic       ser_clk = 1'b0, ser_load_n = 1'b1, ser_data = 1'b0, enh_sel = 1'b0;
    logic [7:0] par_data = '0;
    logic       wr_m1 = 1'b0, wr_m2 = 1'b0, wr_a = 1'b0, hop_wr = 1'b0;
    logic       fsel_ser = 1'b0, fsel_par = 1'b0, enh_en_n = 1'b1;
    logic [6:0] dir_m = '0;
    logic       dir_pe = 1'b0;
    logic [3:0] dir_a = '0, dir_r = '0;
    logic [8:0] m_out;
    logic [3:0] a_out;
    logic [5:0] r_out;
    logic       pe_out;
    logic [7:0] enh_out;

    int total = 0;
    int bad = 0;
    logic [19:0] exp_prim = '0, exp_sec = '0;
    logic [7:0]  exp_enh = '0;

    always #2 clk = ~clk;

    pllcfg_front dut (.*);

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_word(input string tag, input logic [19:0] w);
        check({tag, " M"}, int'(m_out), int'(w[12:4]));
        check({tag, " A"}, int'(a_out), int'(w[3:0]));
        check({tag, " R"}, int'(r_out), int'(w[19:14]));
        check({tag, " PE"}, int'(pe_out), int'(w[13]));
    endtask

    // 0:m1 1:m2 2:a 3:hop 4:enh_sel 5:ser_clk
    task automatic strobe(input int which);
        case (which)
            0: wr_m1 = 1'b1;
            1: wr_m2 = 1'b1;
            2: wr_a = 1'b1;
            3: hop_wr = 1'b1;
            4: enh_sel = 1'b1;
            default: ser_clk = 1'b1;
        endcase
        idle(5);
        {wr_m1, wr_m2, wr_a, hop_wr, enh_sel, ser_clk} = '0;
        idle(5);
    endtask

    task automatic shift_bits(input logic [19:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            idle(3);
            ser_clk = 1'b1;
            idle(4);
            ser_clk = 1'b0;
            idle(3);
        end
    endtask

    task automatic t_reset;
        check_word("R6 reset", 20'h0);
        check("R11 reset enh", int'(enh_out), 0);
    endtask

    task automatic t_direct;
        mode_direct = 1'b1; dir_m = 7'h5B; dir_pe = 1'b1; dir_a = 4'hD; dir_r = 4'h6;
        enh_en_n = 1'b0;
        idle(6);
        check("R1 direct M", int'(m_out), 9'h05B);
        check("R1 direct A", int'(a_out), 4'hD);
        check("R1 direct R", int'(r_out), 6'h06);
        check("R1 direct PE", int'(pe_out), 1);
        check("R11 direct enh", int'(enh_out), 0);
        enh_en_n = 1'b1;
        mode_direct = 1'b0;
        idle(6);
    endtask

    task automatic t_parallel;
        fsel_par = 1'b1;
        par_data = 8'hA5; strobe(0);
        exp_prim[13] = 1'b1; exp_prim[10:4] = 7'h25;
        check_word("R7 m1 write", exp_prim);
        par_data = 8'h0E; strobe(1);
        exp_prim[19:18] = 2'b11; exp_prim[12:11] = 2'b10;
        check_word("R8 m2 write", exp_prim);
        par_data = 8'h9C; strobe(2);
        exp_prim[17:14] = 4'h9; exp_prim[3:0] = 4'hC;
        check_word("R9 a write", exp_prim);
        fsel_par = 1'b0;
        idle(2);
        check_word("R6 held word", exp_sec);
    endtask

    task automatic t_hop_and_write;
        par_data = 8'h41;
        wr_a = 1'b1; hop_wr = 1'b1;
        idle(5);
        wr_a = 1'b0; hop_wr = 1'b0;
        idle(5);
        exp_sec = exp_prim;
        exp_prim[17:14] = 4'h4; exp_prim[3:0] = 4'h1;
        check_word("R13 held gets old", exp_sec);
        fsel_par = 1'b1;
        idle(2);
        check_word("R13 working new", exp_prim);
        strobe(3);
        exp_sec = exp_prim;
        fsel_par = 1'b0;
        idle(2);
        check_word("R5 hop copy", exp_sec);
    endtask

    task automatic t_par_enh;
        par_data = 8'h3C; strobe(4);
        exp_enh = 8'h3C;
        check("R11 gated off", int'(enh_out), 0);
        enh_en_n = 1'b0;
        idle(2);
        check("R10 enh write", int'(enh_out), int'(exp_enh));
        strobe(5);
        fsel_par = 1'b1;
        idle(2);
        check_word("R12 sclk in parallel", exp_prim);
    endtask

    task automatic t_serial;
        mode_serial = 1'b1; fsel_ser = 1'b1;
        idle(6);
        ser_load_n = 1'b0;
        idle(4);
        shift_bits(20'hB5E37, 20);
        exp_prim = 20'hB5E37;
        check_word("R2 serial word", exp_prim);
        fsel_ser = 1'b0;
        idle(2);
        check_word("R4 held before load", exp_sec);
        ser_load_n = 1'b1;
        idle(6);
        exp_sec = exp_prim;
        check_word("R4 load copy", exp_sec);
        strobe(5);
        fsel_ser = 1'b1;
        idle(2);
        check_word("R2 no shift when load high", exp_prim);
        par_data = 8'hFF; strobe(0); strobe(2);
        check_word("R12 field write in serial", exp_prim);
        enh_sel = 1'b1;
        idle(4);
        ser_load_n = 1'b0;
        idle(4);
        shift_bits(20'h0005A, 8);
        ser_load_n = 1'b1;
        idle(6);
        enh_sel = 1'b0;
        idle(6);
        exp_enh = 8'h5A;
        check("R3 serial enh", int'(enh_out), int'(exp_enh));
        check_word("R3 working untouched", exp_prim);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(4);
        t_reset();
        t_direct();
        t_parallel();
        t_hop_and_write();
        t_par_enh();
        t_serial();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule